// File: doc/BRIEF.md
# DMA Bus Hold Limiter

This block sits between a multi-channel DMA engine and the system bus arbiter and caps how long the DMA engine may keep the bus in one stretch. While the engine owns the bus, the block counts system clocks. Once the programmed ceiling is reached and the engine signals that it is between bus cycles, the block withdraws the bus request even though work is still pending. It then stays off the bus for a fixed gap, so that other masters can be served, and afterwards requests the bus again so the remaining transfer can go on.

The ceiling comes from one control register: an enable flag and a limit value. The limit is counted in units of a fixed number of clocks. The count covers all channels together, and it restarts on every new grant. The register can only be changed while every channel enable bit is zero. Each forced release also sends a one-cycle pulse that clears any pending software-start flags in the DMA engine. When the engine finishes before the ceiling, the bus is released at once and no gap is inserted.

Top module: `busHoldLimiter`

## Requirements
- R1: After reset, `busReq`, `ownGrant` and `swStartClr` are 0 and `cfgValue` is 0.
- R2: A register write (`cfgWrEn` high at a clock edge) updates `cfgValue` at that edge only if `chanEnable` is all zero. While any channel enable bit is set, the write is discarded and `cfgValue` keeps its value.
- R3: Bit LIMIT_W of the register (bit 7 by default) is the timer enable and bits LIMIT_W-1..0 are the limit value. A write with the enable bit at 1 and a limit value of 0 is discarded as a whole.
- R4: From idle, `dmaReq` high at an edge raises `busReq` after that edge. `ownGrant` rises on the edge after `busGrant` is seen high while requesting.
- R5: With the timer enabled and `dmaIdle` held high, a forced release ends ownership after exactly limit×UNIT_CYCLES cycles of `ownGrant` high, while `dmaReq` stays high.
- R6: A forced release happens only on an edge where `dmaIdle` is high. While `dmaIdle` is low past the ceiling, ownership continues, and it ends on the edge after `dmaIdle` returns high.
- R7: After a forced release, `busReq` stays low for exactly BACKOFF_LEN (16) cycles. It then rises again if `dmaReq` is still high.
- R8: `swStartClr` is high for exactly one cycle per forced release: the first cycle of the gap. It never pulses at any other time.
- R9: If `dmaReq` drops while the bus is owned, `busReq` and `ownGrant` fall after the next edge without a pulse, and a new `dmaReq` is requested on the following edge with no gap.
- R10: The hold count restarts on every new grant, including the grant after a gap. Changes of `chanEnable` during ownership do not affect it.
- R11: With the timer disabled, ownership lasts as long as `dmaReq` is high and no forced release occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Register write strobe |
| cfgWrData | input | LIMIT_W+1 | Write data: enable in top bit, limit value below |
| cfgValue | output | LIMIT_W+1 | Current register contents |
| chanEnable | input | NUM_CH | Per-channel enable vector from the DMA engine |
| dmaReq | input | 1 | DMA engine has transfer work pending |
| dmaIdle | input | 1 | DMA engine is at a bus-cycle boundary |
| busReq | output | 1 | Bus request to the arbiter |
| busGrant | input | 1 | Bus grant from the arbiter |
| ownGrant | output | 1 | DMA engine may use the bus this cycle |
| swStartClr | output | 1 | One-cycle pulse that clears pending software-start flags |

## Verification
Every cycle, the assertions check several rules. Writes are discarded while channels are enabled, and the stored register never holds an enabled zero limit. Ownership only starts after a grant. Each clear pulse is single, follows an owned cycle at a bus-cycle boundary with the timer on, and is followed by a gap with the request low. Exact lengths can only be shown by the bench's scenarios. These are the hold time for each limit value, the deferral length under a late idle indication, and the absence of a gap after normal completion. The bench also shows that the count restarts on each new grant.

// File: rtl/blimPkg.sv
package blimPkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_OWN,
    ST_BACK
  } blimState_t;

  typedef struct packed {
    logic clrOcc;    // restart the hold count
    logic incOcc;    // count one owned cycle
    logic clrBo;     // restart the gap count
    logic incBo;     // count one gap cycle
    logic forceRel;  // forced release happens on this edge
  } blimStrobe_t;

endpackage

// File: rtl/blimCtrl.sv
module blimCtrl
  import blimPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        dmaReq,
  input  logic        dmaIdle,
  input  logic        busGrant,
  input  logic        occExpired,
  input  logic        boDone,
  output blimStrobe_t strobe,
  output logic        busReq,
  output logic        ownGrant
);

  blimState_t state, nextState;

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (dmaReq) nextState = ST_REQ;
      end
      ST_REQ: begin
        if (busGrant) begin
          nextState     = ST_OWN;
          strobe.clrOcc = 1'b1;
        end
      end
      ST_OWN: begin
        strobe.incOcc = 1'b1;
        if (!dmaReq) begin
          nextState = ST_IDLE;
        end else if (occExpired && dmaIdle) begin
          nextState       = ST_BACK;
          strobe.forceRel = 1'b1;
          strobe.clrBo    = 1'b1;
        end
      end
      ST_BACK: begin
        strobe.incBo = 1'b1;
        if (boDone) nextState = dmaReq ? ST_REQ : ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign busReq   = (state == ST_REQ) || (state == ST_OWN);
  assign ownGrant = (state == ST_OWN);

endmodule

// File: rtl/blimData.sv
module blimData
  import blimPkg::*;
#(
  parameter int NUM_CH      = 6,
  parameter int LIMIT_W     = 7,
  parameter int UNIT_CYCLES = 256,
  parameter int BACKOFF_LEN = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [LIMIT_W:0]   cfgWrData,
  input  logic [NUM_CH-1:0]  chanEnable,
  input  blimStrobe_t        strobe,
  output logic [LIMIT_W:0]   cfgValue,
  output logic               occExpired,
  output logic               boDone,
  output logic               swStartClr
);

  localparam int UNIT_SH = $clog2(UNIT_CYCLES);
  localparam int OCC_W   = LIMIT_W + UNIT_SH + 1;
  localparam int BO_W    = $clog2(BACKOFF_LEN) + 1;

  logic [LIMIT_W:0]   cfgReg;
  logic [OCC_W-1:0]   occCnt;
  logic [OCC_W-1:0]   limitCycles;
  logic [BO_W-1:0]    boCnt;
  logic               timerOn;
  logic [LIMIT_W-1:0] limitVal;
  logic               wrOk;

  assign timerOn  = cfgReg[LIMIT_W];
  assign limitVal = cfgReg[LIMIT_W-1:0];

  // Register write: only with all channels off, and never an enabled zero limit.
  assign wrOk = cfgWrEn && (chanEnable == '0) &&
                !(cfgWrData[LIMIT_W] && (cfgWrData[LIMIT_W-1:0] == '0));

  always_ff @(posedge clk) begin
    if (!rstN)     cfgReg <= '0;
    else if (wrOk) cfgReg <= cfgWrData;
  end

  generate
    if ((UNIT_CYCLES & (UNIT_CYCLES - 1)) == 0) begin : g_unitShift
      assign limitCycles = OCC_W'(limitVal) << UNIT_SH;
    end else begin : g_unitMul
      assign limitCycles = OCC_W'(limitVal) * OCC_W'(UNIT_CYCLES);
    end
  endgenerate

  assign occExpired = timerOn && (occCnt == limitCycles - OCC_W'(1));

  // Hold count: restarts per grant, stays at zero with the timer off,
  // saturates once the ceiling is reached.
  always_ff @(posedge clk) begin
    if (!rstN || strobe.clrOcc || !timerOn) occCnt <= '0;
    else if (strobe.incOcc && !occExpired)  occCnt <= occCnt + OCC_W'(1);
  end

  assign boDone = (boCnt == BO_W'(BACKOFF_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clrBo) boCnt <= '0;
    else if (strobe.incBo)     boCnt <= boCnt + BO_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) swStartClr <= 1'b0;
    else       swStartClr <= strobe.forceRel;
  end

  assign cfgValue = cfgReg;

endmodule

// File: rtl/busHoldLimiter.sv
module busHoldLimiter
  import blimPkg::*;
#(
  parameter int NUM_CH      = 6,
  parameter int LIMIT_W     = 7,
  parameter int UNIT_CYCLES = 256,
  parameter int BACKOFF_LEN = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [LIMIT_W:0]  cfgWrData,
  output logic [LIMIT_W:0]  cfgValue,
  input  logic [NUM_CH-1:0] chanEnable,
  input  logic              dmaReq,
  input  logic              dmaIdle,
  output logic              busReq,
  input  logic              busGrant,
  output logic              ownGrant,
  output logic              swStartClr
);

  blimStrobe_t strobe;
  logic        occExpired;
  logic        boDone;

  blimCtrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .dmaReq     (dmaReq),
    .dmaIdle    (dmaIdle),
    .busGrant   (busGrant),
    .occExpired (occExpired),
    .boDone     (boDone),
    .strobe     (strobe),
    .busReq     (busReq),
    .ownGrant   (ownGrant)
  );

  blimData #(
    .NUM_CH      (NUM_CH),
    .LIMIT_W     (LIMIT_W),
    .UNIT_CYCLES (UNIT_CYCLES),
    .BACKOFF_LEN (BACKOFF_LEN)
  ) data_i (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWrEn    (cfgWrEn),
    .cfgWrData  (cfgWrData),
    .chanEnable (chanEnable),
    .strobe     (strobe),
    .cfgValue   (cfgValue),
    .occExpired (occExpired),
    .boDone     (boDone),
    .swStartClr (swStartClr)
  );

endmodule

// File: rtl/busHoldLimiterChk.sv
module busHoldLimiterChk #(
  parameter int NUM_CH      = 6,
  parameter int LIMIT_W     = 7,
  parameter int BACKOFF_LEN = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [LIMIT_W:0]  cfgValue,
  input logic [NUM_CH-1:0] chanEnable,
  input logic              dmaReq,
  input logic              dmaIdle,
  input logic              busReq,
  input logic              busGrant,
  input logic              ownGrant,
  input logic              swStartClr
);

  localparam int GAP_W = $clog2(BACKOFF_LEN) + 1;

  logic [GAP_W-1:0] gapCnt;

  always_ff @(posedge clk) begin
    if (!rstN)            gapCnt <= '0;
    else if (swStartClr)  gapCnt <= GAP_W'(BACKOFF_LEN - 1);
    else if (gapCnt != 0) gapCnt <= gapCnt - GAP_W'(1);
  end

  assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (chanEnable != '0) |=> $stable(cfgValue));

  assert_legal_limit_R3: assert property (@(posedge clk) disable iff (!rstN)
    cfgValue[LIMIT_W] |-> (cfgValue[LIMIT_W-1:0] != '0));

  assert_own_after_grant_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ownGrant) |-> $past(busGrant));

  assert_req_from_dma_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busReq) |-> $past(dmaReq));

  assert_idle_boundary_R6: assert property (@(posedge clk) disable iff (!rstN)
    swStartClr |-> $past(dmaIdle));

  assert_gap_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    (gapCnt != 0) |-> !busReq);

  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    swStartClr |=> !swStartClr);

  assert_pulse_from_own_R8: assert property (@(posedge clk) disable iff (!rstN)
    swStartClr |-> ($past(ownGrant) && !busReq));

  assert_timer_gate_R11: assert property (@(posedge clk) disable iff (!rstN)
    swStartClr |-> $past(cfgValue[LIMIT_W]));

endmodule

bind busHoldLimiter busHoldLimiterChk #(
  .NUM_CH      (NUM_CH),
  .LIMIT_W     (LIMIT_W),
  .BACKOFF_LEN (BACKOFF_LEN)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .cfgValue   (cfgValue),
  .chanEnable (chanEnable),
  .dmaReq     (dmaReq),
  .dmaIdle    (dmaIdle),
  .busReq     (busReq),
  .busGrant   (busGrant),
  .ownGrant   (ownGrant),
  .swStartClr (swStartClr)
);

// File: tb/busHoldLimiter_tb_top.sv
`timescale 1ns/1ps
module busHoldLimiter_tb_top;

  localparam int NUM_CH  = 6;
  localparam int LIMIT_W = 7;
  localparam int UNIT    = 4;
  localparam int GAP     = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cfgWrEn = 1'b0;
  logic [LIMIT_W:0]  cfgWrData = '0;
  logic [LIMIT_W:0]  cfgValue;
  logic [NUM_CH-1:0] chanEnable = '0;
  logic              dmaReq = 1'b0;
  logic              dmaIdle = 1'b1;
  logic              busReq;
  logic              busGrant = 1'b0;
  logic              ownGrant;
  logic              swStartClr;

  int nTests = 0;
  int nFail  = 0;

  always #2 clk = ~clk;  // 250 MHz

  // Arbiter model: grants one half cycle after the request is seen.
  always @(negedge clk) busGrant <= busReq;

  busHoldLimiter #(
    .NUM_CH      (NUM_CH),
    .LIMIT_W     (LIMIT_W),
    .UNIT_CYCLES (UNIT),
    .BACKOFF_LEN (GAP)
  ) dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWrEn    (cfgWrEn),
    .cfgWrData  (cfgWrData),
    .cfgValue   (cfgValue),
    .chanEnable (chanEnable),
    .dmaReq     (dmaReq),
    .dmaIdle    (dmaIdle),
    .busReq     (busReq),
    .busGrant   (busGrant),
    .ownGrant   (ownGrant),
    .swStartClr (swStartClr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeCfg(input logic [LIMIT_W:0] d, input logic [NUM_CH-1:0] ch);
    chanEnable = ch;
    cfgWrData  = d;
    cfgWrEn    = 1'b1;
    @(negedge clk);
    cfgWrEn    = 1'b0;
  endtask

  task automatic waitOwn();
    while (!ownGrant) @(negedge clk);
  endtask

  // Counts owned cycles; raises dmaIdle once `idleAt` cycles are counted.
  task automatic countOwn(input int idleAt, output int cnt, output int pulses);
    cnt = 0; pulses = 0;
    while (ownGrant) begin
      cnt++;
      if (swStartClr) pulses++;
      if (cnt == idleAt) dmaIdle = 1'b1;
      if (cnt == 3) chanEnable = ~chanEnable;  // R10: enables change mid-hold
      @(negedge clk);
    end
  endtask

  // Forced release with deferral `extra`, then the gap and the resumed hold.
  task automatic forcedRun(input int lim, input int extra, input string tag);
    int cnt, pulses, gap, cnt2, p2;
    writeCfg({1'b1, LIMIT_W'(lim)}, '0);
    chanEnable = NUM_CH'(lim % 63 + 1);
    dmaIdle = (extra == 0);
    dmaReq  = 1'b1;
    @(negedge clk);
    waitOwn();
    countOwn(lim * UNIT + extra, cnt, pulses);
    chk(cnt == lim * UNIT + extra, tag, cnt, lim * UNIT + extra);
    chk(pulses == 0, "R8 no pulse while owning", pulses, 0);
    chk(swStartClr == 1'b1 && busReq == 1'b0, "R8 pulse in first gap cycle", swStartClr, 1);
    gap = 0;
    while (!busReq && gap < 100) begin
      gap++;
      @(negedge clk);
      if (gap == 1) chk(swStartClr == 1'b0, "R8 pulse one cycle", swStartClr, 0);
    end
    chk(gap == GAP, "R7 gap length", gap, GAP);
    waitOwn();
    dmaIdle = 1'b1;
    countOwn(1, cnt2, p2);
    chk(cnt2 == lim * UNIT, "R10 resumed hold restarts count", cnt2, lim * UNIT);
    dmaReq = 1'b0;
    repeat (GAP + 2) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin : mainSeq
    int cnt, pulses;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    chk(busReq == 0 && ownGrant == 0 && swStartClr == 0, "R1 outputs after reset",
        {busReq, ownGrant, swStartClr}, 0);
    chk(cfgValue == 0, "R1 register after reset", cfgValue, 0);

    // R2: accepted with channels off
    writeCfg(8'h25, '0);
    chk(cfgValue == 8'h25, "R2 write accepted", cfgValue, 8'h25);
    // R2: blocked for every nonzero enable mask
    for (int m = 1; m < (1 << NUM_CH); m++) begin
      writeCfg(8'h80 | 8'(m), NUM_CH'(m));
      chk(cfgValue == 8'h25, "R2 write blocked", cfgValue, 8'h25);
    end
    // R3: enabled with zero limit is discarded
    writeCfg(8'h80, '0);
    chk(cfgValue == 8'h25, "R3 enabled zero limit ignored", cfgValue, 8'h25);
    writeCfg(8'h00, '0);
    chk(cfgValue == 8'h00, "R3 disabled zero limit accepted", cfgValue, 0);

    // R4 and R11: timer off, long hold, no forced release
    writeCfg(8'h05, '0);
    dmaReq = 1'b1;
    @(negedge clk);
    chk(busReq == 1, "R4 request after dmaReq", busReq, 1);
    @(negedge clk);
    chk(ownGrant == 1, "R4 own after grant", ownGrant, 1);
    pulses = 0; cnt = 0;
    for (int i = 0; i < 2000; i++) begin
      if (ownGrant) cnt++;
      if (swStartClr) pulses++;
      @(negedge clk);
    end
    chk(cnt == 2000 && pulses == 0, "R11 timer off keeps bus", cnt, 2000);
    dmaReq = 1'b0;
    repeat (3) @(negedge clk);

    // R5 sweep over every limit value
    for (int l = 1; l < (1 << LIMIT_W); l++) forcedRun(l, 0, "R5 hold length");

    // R6 deferral by a late idle indication
    for (int e = 1; e <= 9; e += 4) forcedRun(3, e, "R6 deferred release");

    // R9 normal completion: no gap, no pulse, then full count (R10)
    writeCfg({1'b1, 7'd10}, '0);
    dmaReq = 1'b1;
    @(negedge clk);
    waitOwn();
    cnt = 0;
    while (cnt < 20) begin cnt++; if (cnt < 20) @(negedge clk); end
    dmaReq = 1'b0;
    @(negedge clk);
    chk(busReq == 0 && ownGrant == 0 && swStartClr == 0, "R9 normal release",
        {busReq, ownGrant, swStartClr}, 0);
    dmaReq = 1'b1;
    @(negedge clk);
    chk(busReq == 1, "R9 no gap after normal release", busReq, 1);
    waitOwn();
    countOwn(1, cnt, pulses);
    chk(cnt == 40, "R10 count restarts per grant", cnt, 40);
    dmaReq = 1'b0;
    repeat (GAP + 2) @(negedge clk);
    chk(busReq == 0, "R7 idle after gap without dmaReq", busReq, 0);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule